// File: doc/BRIEF.md
# ADC Result Holding Registers with Read Interlock and Auto-Compare

This block sits between an analog-to-digital converter core and a CPU register bus. Each time the core signals a finished conversion, the block decides whether to keep the result and what value to keep. It then holds that value in two byte-wide, read-only bus registers: a high byte and a low byte. Two more byte registers hold a 12-bit compare value that software can read and write.

With automatic compare off, every finished conversion is stored, masked to the active resolution of 8, 10 or 12 bits. With compare on, a result is kept only when it meets the selected condition against the compare value, and what is kept is the signed difference, truncated to the resolution. In the wider modes a read of the high byte locks the pair until the low byte is read. Software therefore never sees a high byte and a low byte from different conversions. A level output tells software that a new result is waiting.

Top module: `adc_result_ctl`

## Requirements
- R1: The stored result is the raw value masked to the active width. Mode encodings are `00` = 8-bit, `01` = 10-bit, `10` or `11` = 12-bit. The low byte (address 1) returns stored bits 7..0; in 8-bit mode these are all of the result.
- R2: The high byte (address 0) returns stored bits 11..8 in bits 3..0 and zero in bits 7..4. Both bytes read zero after reset.
- R3: With compare enabled, a conversion that misses the condition leaves both result bytes unchanged.
- R4: With compare enabled, a conversion that meets the condition stores (result - compare) modulo 2^width.
- R5: In 10-bit and 12-bit modes, a read of the high byte blocks storage, including a conversion finishing in that same cycle, until the low byte is read.
- R6: Conversions that finish while storage is blocked are lost. A conversion that finishes after the low-byte read is stored.
- R7: In 8-bit mode a high-byte read sets no block, and the next conversion is stored.
- R8: The compare high register (address 2) keeps write bits 3..0 and reads zero in bits 7..4. The compare low register (address 3) keeps all eight bits. The compare uses only the active width. With `cmp_ge` = 1 the condition is result >= compare; with `cmp_ge` = 0 it is result < compare.
- R9: A change of `mode_sel` clears both result bytes, the block and `conv_done`, and discards a conversion arriving in that cycle.
- R10: `conv_done` rises in the cycle after a result is stored. It falls after a low-byte read, unless a store happens in the same cycle.
- R11: Bus writes to addresses 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Resolution select |
| cmp_en | input | 1 | Automatic compare enable |
| cmp_ge | input | 1 | Compare condition select |
| conv_valid | input | 1 | One-cycle conversion-finished strobe |
| conv_data | input | 12 | Raw right-justified conversion result |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| conv_done | output | 1 | New result waiting |

## Verification
A block flag stuck high shows as stale low bytes on the very next read pair: the conversion after a low-byte read is lost. A missing block shows as a low byte that belongs to a later conversion than its high byte. A bad compare or mask path shows on the first read after the offending conversion, as a wrong difference or as bits above the active width. A missed clear on a mode change shows as a nonzero byte read in the first cycle after the change.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int HI_W   = RES_W - BYTE_W;

    typedef enum logic [1:0] {
        MODE_8   = 2'b00,
        MODE_10  = 2'b01,
        MODE_12  = 2'b10,
        MODE_12X = 2'b11
    } mode_e;

    typedef enum logic [ADDR_W-1:0] {
        A_RES_HI = 2'd0,
        A_RES_LO = 2'd1,
        A_CMP_HI = 2'd2,
        A_CMP_LO = 2'd3
    } addr_e;

    typedef struct packed {
        logic             store;
        logic [RES_W-1:0] value;
    } cap_t;

    function automatic logic [RES_W-1:0] width_mask(mode_e m);
        case (m)
            MODE_8:  return RES_W'(12'h0FF);
            MODE_10: return RES_W'(12'h3FF);
            default: return {RES_W{1'b1}};
        endcase
    endfunction

    function automatic logic is_wide(mode_e m);
        return m != MODE_8;
    endfunction
endpackage

// File: rtl/adcr_cmp_unit.sv
module adcr_cmp_unit
    import adcr_pkg::*;
(
    input  mode_e            mode,
    input  logic [RES_W-1:0] raw,
    input  logic [RES_W-1:0] cmp_val,
    input  logic             cmp_en,
    input  logic             cmp_ge,
    output cap_t             cap
);
    logic [RES_W-1:0] msk, r_m, c_m, diff;
    logic             met;

    always_comb begin
        msk  = width_mask(mode);
        r_m  = raw & msk;
        c_m  = cmp_val & msk;
        met  = cmp_ge ? (r_m >= c_m) : (r_m < c_m);
        diff = (r_m + (~c_m + RES_W'(1))) & msk;
        cap.store = !cmp_en || met;
        cap.value = cmp_en ? diff : r_m;
    end
endmodule

// File: rtl/adcr_interlock.sv
module adcr_interlock
    import adcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_chg,
    input  logic wide,
    input  logic hi_rd,
    input  logic lo_rd,
    output logic locked,
    output logic block
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst || mode_chg)      lock_q <= 1'b0;
        else if (lo_rd)           lock_q <= 1'b0;
        else if (hi_rd && wide)   lock_q <= 1'b1;
    end

    assign locked = lock_q;
    assign block  = lock_q || (hi_rd && wide);

    AST_NARROW_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && !wide && !lock_q) |=> !lock_q); // R7
    AST_LO_READ_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> !lock_q); // R6
endmodule

// File: rtl/adcr_cmp_regs.sv
module adcr_cmp_regs
    import adcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  addr_e             addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [RES_W-1:0]  cmp_val
);
    logic [HI_W-1:0]   hi_q;
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CMP_HI) hi_q <= wdata[HI_W-1:0];
            if (addr == A_CMP_LO) lo_q <= wdata;
        end
    end

    assign cmp_val = {hi_q, lo_q};
endmodule

// File: rtl/adc_result_ctl.sv
module adc_result_ctl
    import adcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_sel,
    input  logic        cmp_en,
    input  logic        cmp_ge,
    input  logic        conv_valid,
    input  logic [11:0] conv_data,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        conv_done
);
    mode_e            mode_in, mode_q;
    addr_e            addr;
    logic             mode_chg, hi_rd, lo_rd, block, locked, take;
    logic [RES_W-1:0] cmp_val, res_q;
    logic             flag_q;
    cap_t             cap;

    assign mode_in  = mode_e'(mode_sel);
    assign addr     = addr_e'(bus_addr);
    assign mode_chg = (mode_in != mode_q);
    assign hi_rd    = bus_rd && (addr == A_RES_HI);
    assign lo_rd    = bus_rd && (addr == A_RES_LO);

    adcr_cmp_regs u_cmp_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(addr),
        .wdata(bus_wdata), .cmp_val(cmp_val)
    );

    adcr_cmp_unit u_cmp (
        .mode(mode_in), .raw(conv_data), .cmp_val(cmp_val),
        .cmp_en(cmp_en), .cmp_ge(cmp_ge), .cap(cap)
    );

    adcr_interlock u_lock (
        .clk(clk), .rst(rst), .mode_chg(mode_chg), .wide(is_wide(mode_in)),
        .hi_rd(hi_rd), .lo_rd(lo_rd), .locked(locked), .block(block)
    );

    assign take = conv_valid && cap.store && !block && !mode_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_8;
            res_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            mode_q <= mode_in;
            if (mode_chg) begin
                res_q  <= '0;
                flag_q <= 1'b0;
            end else if (take) begin
                res_q  <= cap.value;
                flag_q <= 1'b1;
            end else if (lo_rd) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            A_RES_HI: bus_rdata = {{(BYTE_W-HI_W){1'b0}}, res_q[RES_W-1:BYTE_W]};
            A_RES_LO: bus_rdata = res_q[BYTE_W-1:0];
            A_CMP_HI: bus_rdata = {{(BYTE_W-HI_W){1'b0}}, cmp_val[RES_W-1:BYTE_W]};
            default:  bus_rdata = cmp_val[BYTE_W-1:0];
        endcase
    end

    assign conv_done = flag_q;

    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (hi_rd || addr == A_CMP_HI)) |-> (bus_rdata[7:4] == 4'h0)); // R2
    AST_WITHIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (res_q & ~width_mask(mode_q)) == '0); // R1
    AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && conv_valid && !cap.store && !mode_chg) |=> $stable(res_q)); // R3
    AST_LOCKED_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (locked && !mode_chg) |=> $stable(res_q)); // R6
    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (res_q == '0 && !conv_done)); // R9
    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        (lo_rd && !conv_valid) |=> !conv_done); // R10
endmodule

// File: tb/adc_result_ctl_tb.sv
module adc_result_ctl_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic        cmp_en, cmp_ge, conv_valid, bus_wr, bus_rd;
    logic [11:0] conv_data;
    logic [1:0]  bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        conv_done;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sbq[$];

    logic [11:0] m_res, m_cmp;
    logic        m_lock, m_flag;

    always #(CLK_P/2) clk = ~clk;

    adc_result_ctl dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cmp_en(cmp_en), .cmp_ge(cmp_ge),
        .conv_valid(conv_valid), .conv_data(conv_data), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .conv_done(conv_done)
    );

    function automatic logic [11:0] msk(logic [1:0] m);
        return (m == 2'b00) ? 12'h0FF : (m == 2'b01) ? 12'h3FF : 12'hFFF;
    endfunction

    // monitor: pops expected read data while a read strobe is active
    initial forever begin
        @(negedge clk);
        #(CLK_P/4);
        if (bus_rd) begin
            item_t it;
            n_chk++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL %s: unexpected read, got %02h", "scoreboard", bus_rdata);
            end else begin
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input string tag);
        item_t it;
        case (a)
            2'd0: it.exp = {4'h0, m_res[11:8]};
            2'd1: it.exp = m_res[7:0];
            2'd2: it.exp = {4'h0, m_cmp[11:8]};
            default: it.exp = m_cmp[7:0];
        endcase
        it.tag = tag;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 2'd0 && mode_sel != 2'b00) m_lock = 1'b1;
        if (a == 2'd1) begin m_lock = 1'b0; m_flag = 1'b0; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd2) m_cmp[11:8] = d[3:0];
        if (a == 2'd3) m_cmp[7:0]  = d;
    endtask

    task automatic conv(input logic [11:0] v);
        logic [11:0] mk, r, c;
        logic met;
        conv_valid = 1'b1; conv_data = v;
        @(negedge clk);
        conv_valid = 1'b0;
        mk = msk(mode_sel); r = v & mk; c = m_cmp & mk;
        met = cmp_ge ? (r >= c) : (r < c);
        if (!m_lock && (!cmp_en || met)) begin
            m_res  = cmp_en ? ((r - c) & mk) : r;
            m_flag = 1'b1;
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        if (m != mode_sel) begin m_res = '0; m_lock = 1'b0; m_flag = 1'b0; end
        mode_sel = m;
        @(negedge clk);
    endtask

    task automatic chk_flag(input string tag);
        n_chk++;
        if (conv_done !== m_flag) begin
            n_bad++;
            $display("FAIL %s: conv_done %b expected %b", tag, conv_done, m_flag);
        end
    endtask

    initial begin
        #(CLK_P*100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mode_sel = 2'b00; cmp_en = 1'b0; cmp_ge = 1'b0;
        conv_valid = 1'b0; conv_data = '0; bus_addr = '0; bus_wr = 1'b0;
        bus_wdata = '0; bus_rd = 1'b0;
        m_res = '0; m_cmp = '0; m_lock = 1'b0; m_flag = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(2'd0, "R2 reset high");
        rd(2'd1, "R2 reset low");
        chk_flag("R10 reset flag");

        set_mode(2'b10);
        conv(12'hABC);
        chk_flag("R10 flag set");
        rd(2'd0, "R2 high byte 12-bit");
        conv(12'h123);                    // dropped: block active
        rd(2'd1, "R5 low byte coherent");
        chk_flag("R10 flag cleared");
        conv(12'h456);
        rd(2'd0, "R6 capture after unlock high");
        rd(2'd1, "R6 capture after unlock low");
        wr(2'd1, 8'h77);
        wr(2'd0, 8'h77);
        rd(2'd1, "R11 result low not writable");
        rd(2'd0, "R11 result high not writable");
        rd(2'd1, "R11 unlock");

        conv(12'h789);
        set_mode(2'b01);
        rd(2'd1, "R9 cleared on mode change");
        chk_flag("R9 flag cleared on mode change");
        conv(12'hFFF);
        rd(2'd0, "R1 10-bit high");
        rd(2'd1, "R1 10-bit low");

        set_mode(2'b00);
        conv(12'h1A5);
        rd(2'd0, "R1 8-bit high zero");
        conv(12'h033);
        rd(2'd1, "R7 no block in 8-bit");

        wr(2'd2, 8'hFF);
        rd(2'd2, "R8 compare high nibble");
        wr(2'd3, 8'h20);
        rd(2'd3, "R8 compare low");
        cmp_en = 1'b1; cmp_ge = 1'b1;
        conv(12'h030);
        rd(2'd1, "R4 8-bit width-limited difference");
        conv(12'h010);
        rd(2'd1, "R3 miss keeps value");

        set_mode(2'b10);
        wr(2'd2, 8'h01);
        wr(2'd3, 8'h00);
        conv(12'h080);
        rd(2'd1, "R3 miss after clear");
        conv(12'h180);
        rd(2'd0, "R4 difference high");
        rd(2'd1, "R4 difference low");
        cmp_ge = 1'b0;
        conv(12'h0F0);
        rd(2'd0, "R8 less-than wrap high");
        rd(2'd1, "R8 less-than wrap low");
        chk_flag("R10 flag after low read");

        repeat (3) @(negedge clk);
        n_chk++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d pending expected 0", sbq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule